// File: doc/BRIEF.md
# Timer Tick Prescaler with Deferred Ratio Switching

This block generates the count enable for a free-running timer counter. It does not make a divided clock. It drives a one-cycle `tick` pulse at the bus clock divided by a power of two. The exponent comes from a small select value written by software. With select 0 the tick is high on every enabled cycle. With select N from 1 to 7 the tick comes once every 2^N enabled cycles, so the ratios are /2 through /128.

A free-running 7-bit prescale counter advances on each enabled cycle. A select write is first stored as a pending value, and it becomes active only at the edge where the whole counter wraps back to zero. Every ratio divides 128, so at that instant all ratios agree on a tick boundary. The switch therefore never makes a shortened or a lengthened tick period.

When the enable input is low, the counter is held at zero and no ticks come out. While the counter is held this way, a pending select is made active at once.

Top module: `tim_prescaler`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `tick` is 0, the prescale counter is 0, and both the active and the pending select are 0.
- R2: With `en` held high and active select N (1 to 7), `tick` is high in exactly one cycle of every 2^N consecutive cycles.
- R3: With active select 0 and `en` high, `tick` is high in every cycle after the first enabled edge.
- R4: With a nonzero active select, `tick` is never high in two consecutive cycles.
- R5: A select written while `en` is high does not change the tick spacing until the counter wraps from 127 to 0. Ticks up to and including the wrap follow the old ratio.
- R6: If several selects are written before the apply point, only the last one written becomes active.
- R7: After any edge with `en` low, the counter is 0 and `tick` is 0.
- R8: A select written while `en` is low, or one left pending when `en` goes low, becomes active at once.
- R9: After `en` rises with the counter at zero, the first tick appears in the cycle after the 2^N-th enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Prescaler run enable |
| sel_wr | input | 1 | Write strobe for the divide select |
| sel_in | input | SEL_W | Divide select exponent (tick = clock / 2^sel) |
| tick | output | 1 | Registered one-cycle count enable |

## Verification
The bench writes a new select in the middle of a counting run. A design that applied the select at once would show a tick gap that is neither the old nor the new ratio before the counter reaches 127. Burst writes before the wrap expose a design that latches the first write instead of the last one. Turning `en` off in the middle of a period, and writing while it is off, checks that the counter restarts from zero and that the held select is taken without waiting for a wrap. A design that kept the stale ratio or resumed from the old count would place the first tick wrongly. Select 0 checks the continuous-tick case, and select 7 checks the full-length counter.

// File: rtl/tim_psc_pkg.sv
package tim_psc_pkg;

  // Low-bit mask that marks a tick boundary for a given exponent.
  function automatic int unsigned tick_mask(input int unsigned exp_sel);
    return (32'd1 << exp_sel) - 32'd1;
  endfunction

endpackage

// File: rtl/psc_counter.sv
module psc_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_inc,
  output logic             wrap
);

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign wrap    = run && (cnt_inc == '0);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_inc;
  end

  // R7
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    run |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

endmodule

// File: rtl/psc_select.sv
module psc_select #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wr,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wrap,
  output logic [SEL_W-1:0] act_sel
);

  logic [SEL_W-1:0] pend_q;
  logic [SEL_W-1:0] pend_nxt;
  logic             apply;

  // A write in the same cycle as the apply point is taken along.
  assign pend_nxt = wr ? wr_sel : pend_q;
  assign apply    = !run || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      act_sel <= '0;
    end else begin
      pend_q <= pend_nxt;
      if (apply) act_sel <= pend_nxt;
    end
  end

  // R6
  last_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (pend_q == $past(wr_sel)));

  // R5
  hold_active_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> $stable(act_sel));

endmodule

// File: rtl/psc_tick.sv
module psc_tick
  import tim_psc_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt_inc,
  input  logic [SEL_W-1:0] act_sel,
  output logic             tick
);

  logic [CNT_W-1:0] mask;
  logic             hit;

  assign mask = CNT_W'(tick_mask(32'(act_sel)));
  assign hit  = run && ((cnt_inc & mask) == '0);

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= hit;
  end

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !tick);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && act_sel != '0) |=> !tick);

endmodule

// File: rtl/tim_prescaler.sv
module tim_prescaler #(
  parameter int SEL_W = 3,
  localparam int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_in,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             wrap;
  logic [SEL_W-1:0] act_sel;

  psc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (en),
    .cnt_q   (cnt_q),
    .cnt_inc (cnt_inc),
    .wrap    (wrap)
  );

  psc_select #(.SEL_W(SEL_W)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .run     (en),
    .wr      (sel_wr),
    .wr_sel  (sel_in),
    .wrap    (wrap),
    .act_sel (act_sel)
  );

  psc_tick #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (en),
    .cnt_inc (cnt_inc),
    .act_sel (act_sel),
    .tick    (tick)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && act_sel == '0 && !tick));

  // R5
  switch_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_sel) |-> (cnt_q == '0));

  // R8
  idle_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && sel_wr) |=> (act_sel == $past(sel_in)));

endmodule

// File: tb/tb_tim_prescaler.sv
module tb_tim_prescaler;

  localparam int SEL_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en = 1'b0;
  logic             sel_wr = 1'b0;
  logic [SEL_W-1:0] sel_in = '0;
  logic             tick;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  // Reference state
  int m_cnt = 0;
  int m_act = 0;
  int m_pend = 0;
  bit m_tick = 1'b0;
  bit prev_tick = 1'b0;

  always #5 clk = ~clk;

  tim_prescaler #(.SEL_W(SEL_W)) dut (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .sel_wr (sel_wr),
    .sel_in (sel_in),
    .tick   (tick)
  );

  // Behavioural reference: enabled-edge count modulo 128, ratio from exponent.
  always @(posedge clk) begin
    int nxt_pend;
    if (rst) begin
      m_cnt = 0; m_act = 0; m_pend = 0; m_tick = 1'b0;
    end else begin
      nxt_pend = sel_wr ? int'(sel_in) : m_pend;
      m_pend = nxt_pend;
      if (!en) begin
        m_cnt = 0; m_act = nxt_pend; m_tick = 1'b0;
      end else begin
        m_cnt = (m_cnt + 1) % 128;
        m_tick = ((m_cnt % (2 ** m_act)) == 0);
        if (m_cnt == 0) m_act = nxt_pend;
      end
    end
  end

  task automatic step(input bit e, input bit w, input int s);
    @(negedge clk);
    checks++;
    if (tick !== m_tick) begin
      errors++;
      $display("FAIL %s: tick=%0b expected %0b at %0t", tag, tick, m_tick, $time);
    end
    // R4: no back-to-back ticks with a nonzero ratio
    if (m_act != 0 && tick === 1'b1 && prev_tick) begin
      checks++;
      errors++;
      $display("FAIL R4: tick=1 expected 0 (consecutive) at %0t", $time);
    end
    prev_tick = (tick === 1'b1);
    en = e; sel_wr = w; sel_in = SEL_W'(s);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: running=1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    step(1'b0, 1'b0, 0);
    step(1'b0, 1'b0, 0);
    @(negedge clk); rst = 1'b0;
    step(1'b0, 1'b0, 0);
    // R3: divide by one
    tag = "R3";
    run(20);
    // R8, R9: write while idle, first tick after 4 edges
    tag = "R8";
    step(1'b0, 1'b1, 2);
    step(1'b0, 1'b0, 0);
    tag = "R9";
    run(40);
    // R5: change ratio mid-run, takes effect only at wrap
    tag = "R5";
    step(1'b1, 1'b1, 5);
    run(300);
    // R6: burst of writes, last wins
    tag = "R6";
    step(1'b1, 1'b1, 3);
    step(1'b1, 1'b1, 6);
    step(1'b1, 1'b1, 1);
    run(300);
    // R7: disable mid-period
    tag = "R7";
    run(3);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 0);
    // R8: pending left while running, then idle applies it
    tag = "R8";
    step(1'b1, 1'b1, 7);
    step(1'b0, 1'b0, 0);
    step(1'b0, 1'b0, 0);
    // R2: full-length ratio
    tag = "R2";
    run(400);
    step(1'b0, 1'b1, 4);
    run(100);
    step(1'b0, 1'b1, 0);
    tag = "R3";
    run(10);
    // R1: reset mid-run
    tag = "R1";
    @(negedge clk); rst = 1'b1;
    step(1'b1, 1'b0, 0);
    @(negedge clk); rst = 1'b0;
    step(1'b0, 1'b0, 0);
    tag = "R3";
    run(5);
    step(1'b0, 1'b0, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule